// File: doc/BRIEF.md
# Sequencer Program Memory Loader

This block lets a host fill and inspect the instruction memory of a small embedded sequencer through a narrow byte-wide register port. The host first picks a word position by writing a low address register and a high address register. It then moves bytes through one data window register. Four window writes build one 32-bit instruction word, least significant byte first, and the fourth write stores the word. After the fourth byte the word position steps forward by one. Window reads work the same way and return the stored word one byte at a time in the same order.

A control register carries three bits. The load-enable bit gates all window traffic. The core-reset bit is driven out as a level that holds the sequencer's program counter at zero. The single-step bit produces a one-cycle pulse toward the sequencer. A separate fetch port gives the sequencer core direct read access to whole words. The memory is a plain synthesizable array and is not cleared by reset.

Top module: `seq_pgm_loader`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 0x00, both address registers read 0x00, `core_rst` and `step_pulse` are low, and the byte-lane counter is 0.
- R2: The register select encoding is 0 = control, 1 = data window, 2 = address low, 3 = address high. Accepted window writes are assembled least significant byte first. On the fourth write the word {byte3, byte2, byte1, byte0} is stored at the current word address.
- R3: The word address advances by one only after the fourth accepted window access. After one to three accesses the address reads back unchanged.
- R4: The word address is 9 bits: bits 7:0 come from the address-low register and bit 8 from bit 0 of the address-high register. The other bits written to the address-high register are ignored, and that register reads back with bits 7:1 as zero.
- R5: Writing either address register sets the byte-lane counter to 0, so the next window access uses byte 0 of the newly addressed word.
- R6: Window reads and writes leave the memory, the address and the lane counter unchanged while the load-enable bit (control bit 0) is clear.
- R7: When load is enabled, a window read returns byte `lane` of the word at the current address, least significant first. It advances the lane and the address exactly as a write does.
- R8: The word address wraps from 511 to 0 after the fourth access to word 511.
- R9: Control bit 1 is driven on `core_rst` as a level and reads back. Writing control bit 2 as 1 gives a one-cycle `step_pulse` in the cycle after the write. Bit 2 always reads back as 0.
- R10: `fetch_word` shows, without a clock delay, the stored word at `fetch_addr`. A word stored at a clock edge is visible there immediately after that edge.
- R11: A partly written word (one to three bytes) does not change the memory. The fetch port shows the old word until the fourth byte arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 window, 2 address low, 3 address high |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; has side effects only for the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| core_rst | output | 1 | Holds the sequencer program counter at zero while high |
| step_pulse | output | 1 | One-cycle single-step request |
| fetch_addr | input | 9 | Sequencer fetch word address |
| fetch_word | output | 32 | Word stored at `fetch_addr` |

## Verification
The in-RTL properties check on every cycle that the address holds through partial words, clears the lane counter after address writes, and wraps correctly at the top word. They also check that disabled window traffic leaves the pointer alone, that each stored word lands in the array, and that a step pulse follows only a control write. The byte ordering of the assembled and returned words, and the integrity of every one of the 512 locations after a full sweep, can only be shown by the bench's scenarios. The same holds for the fact that a dropped or disabled partial word leaves the stored content untouched.

// File: rtl/seqld_pkg.sv
// Shared definitions for the sequencer program memory loader.
// Assumes a two-bit register select on the host port.
package seqld_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_WINDOW  = 2'd1,
        SEL_ADDR_LO = 2'd2,
        SEL_ADDR_HI = 2'd3
    } reg_sel_e;

    localparam int CTRL_LOAD_BIT = 0;
    localparam int CTRL_CRST_BIT = 1;
    localparam int CTRL_STEP_BIT = 2;

endpackage

// File: rtl/seqld_ctrl_reg.sv
// Control register of the loader: load enable, core reset level and
// single-step pulse. Assumes writes arrive as one-cycle strobes.
module seqld_ctrl_reg
    import seqld_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [2:0] wbits,
    output logic       load_en,
    output logic       core_rst,
    output logic       step_pulse
);

    // Hold the persistent control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_en  <= 1'b0;
            core_rst <= 1'b0;
        end else if (wr_ctrl) begin
            load_en  <= wbits[CTRL_LOAD_BIT];
            core_rst <= wbits[CTRL_CRST_BIT];
        end
    end

    // Produce a one-cycle step request per write with the step bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) step_pulse <= 1'b0;
        else        step_pulse <= wr_ctrl && wbits[CTRL_STEP_BIT];
    end

    // R9: a step pulse is always caused by a control write in the previous cycle.
    p_step_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |-> $past(wr_ctrl));

endmodule

// File: rtl/seqld_ptr.sv
// Word address and byte-lane pointer. The address is split across a low
// register (8 bits) and a high register (ADDR_W-8 bits). The lane counter
// steps on each accepted window access, and the address steps after the
// last lane. Assumes WORD_BYTES is a power of two and 8 < ADDR_W <= 16.
module seqld_ptr #(
    parameter int ADDR_W     = 9,
    parameter int WORD_BYTES = 4,
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int HI_W      = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [7:0]        lo_data,
    input  logic [HI_W-1:0]   hi_data,
    input  logic              access,
    output logic [ADDR_W-1:0] addr,
    output logic [LANE_W-1:0] lane
);

    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};

    logic last_lane;
    assign last_lane = (lane == LAST_LANE);

    // Lane counter: cleared by address writes, stepped by window accesses.
    always_ff @(posedge clk) begin
        if (!rst_n)                lane <= '0;
        else if (wr_lo || wr_hi)   lane <= '0;
        else if (access)           lane <= lane + LANE_W'(1);
    end

    // Low address byte: loaded by the host or carried by auto-increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                       addr[7:0] <= '0;
        else if (wr_lo)                   addr[7:0] <= lo_data;
        else if (!wr_hi && access && last_lane)
                                          addr[7:0] <= addr[7:0] + 8'd1;
    end

    // High address bits: loaded by the host or taking the carry.
    always_ff @(posedge clk) begin
        if (!rst_n)                       addr[ADDR_W-1:8] <= '0;
        else if (wr_hi)                   addr[ADDR_W-1:8] <= hi_data;
        else if (!wr_lo && access && last_lane && (addr[7:0] == 8'hFF))
                                          addr[ADDR_W-1:8] <= addr[ADDR_W-1:8] + HI_W'(1);
    end

    // R5: any address register write leaves the lane counter at zero.
    p_lane_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> (lane == '0));

    // R3: the address does not move while a word is only partly accessed.
    p_hold_partial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && (!access || !last_lane)) |=> $stable(addr));

    // R8: the top word wraps to word zero after its last byte.
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && access && last_lane && addr == TOP_ADDR) |=> (addr == '0));

endmodule

// File: rtl/seqld_assembler.sv
// Collects the lower byte lanes of a word in a staging register and forms
// the full word when the last lane arrives. Assumes lane comes from
// seqld_ptr and byte_wr is an accepted window write.
module seqld_assembler #(
    parameter int WORD_BYTES = 4,
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = 8 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_wr,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        wbyte,
    output logic              commit,
    output logic [WORD_W-1:0] commit_word
);

    logic [7:0] stage [WORD_BYTES-1];

    // One staging byte per lower lane.
    for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_stage
        // Capture this lane's byte when it is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 stage[g] <= '0;
            else if (byte_wr && lane == LANE_W'(g))     stage[g] <= wbyte;
        end
        assign commit_word[8*g +: 8] = stage[g];
    end

    assign commit_word[WORD_W-1 -: 8] = wbyte;
    assign commit = byte_wr && (lane == LANE_W'(WORD_BYTES - 1));

endmodule

// File: rtl/seqld_pgm_ram.sv
// Program memory array: one synchronous write port and two combinational
// read ports (host window and sequencer fetch). Contents are not reset.
module seqld_pgm_ram #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [WORD_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [WORD_W-1:0] rd_data_b
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Store a committed word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];

    // R2: a committed word is present in the array after the edge.
    p_commit_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/seq_pgm_loader.sv
// Host-side loader for a sequencer program memory. It decodes the
// register port, gates window traffic by load enable, and connects the
// control register, pointer, word assembler and memory. Assumes the host
// asserts at most one strobe per cycle; a write takes priority over a read.
module seq_pgm_loader
    import seqld_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int WORD_BYTES = 4,
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = 8 * WORD_BYTES,
    localparam int HI_W      = ADDR_W - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              core_rst,
    output logic              step_pulse,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [WORD_W-1:0] fetch_word
);

    reg_sel_e          sel;
    logic              load_en;
    logic              wr_ctrl, wr_lo, wr_hi, win_wr, win_rd, win_access;
    logic [ADDR_W-1:0] addr;
    logic [LANE_W-1:0] lane;
    logic              commit;
    logic [WORD_W-1:0] commit_word;
    logic [WORD_W-1:0] win_word;

    assign sel        = reg_sel_e'(reg_sel);
    assign wr_ctrl    = wr_en && (sel == SEL_CTRL);
    assign wr_lo      = wr_en && (sel == SEL_ADDR_LO);
    assign wr_hi      = wr_en && (sel == SEL_ADDR_HI);
    assign win_wr     = wr_en && (sel == SEL_WINDOW) && load_en;
    assign win_rd     = rd_en && !wr_en && (sel == SEL_WINDOW) && load_en;
    assign win_access = win_wr || win_rd;

    seqld_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wbits      (wdata[2:0]),
        .load_en    (load_en),
        .core_rst   (core_rst),
        .step_pulse (step_pulse)
    );

    seqld_ptr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .lo_data (wdata),
        .hi_data (wdata[HI_W-1:0]),
        .access  (win_access),
        .addr    (addr),
        .lane    (lane)
    );

    seqld_assembler #(.WORD_BYTES(WORD_BYTES)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_wr     (win_wr),
        .lane        (lane),
        .wbyte       (wdata),
        .commit      (commit),
        .commit_word (commit_word)
    );

    seqld_pgm_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit),
        .wr_addr   (addr),
        .wr_data   (commit_word),
        .rd_addr_a (addr),
        .rd_data_a (win_word),
        .rd_addr_b (fetch_addr),
        .rd_data_b (fetch_word)
    );

    // Read multiplexer for the selected register.
    always_comb begin
        unique case (sel)
            SEL_CTRL:    rdata = {6'd0, core_rst, load_en};
            SEL_WINDOW:  rdata = win_word[8*lane +: 8];
            SEL_ADDR_LO: rdata = addr[7:0];
            SEL_ADDR_HI: rdata = 8'(addr[ADDR_W-1:8]);
            default:     rdata = '0;
        endcase
    end

    // R6: disabled window traffic leaves the pointer untouched.
    p_ignore_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && sel == SEL_WINDOW && !load_en) |=> ($stable(addr) && $stable(lane)));

endmodule

// File: tb/tb_seq_pgm_loader.sv
`timescale 1ns/1ps
module tb_seq_pgm_loader;

    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic        core_rst, step_pulse;
    logic [8:0]  fetch_addr = 9'd0;
    logic [31:0] fetch_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] model [DEPTH];

    seq_pgm_loader dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .core_rst(core_rst),
        .step_pulse(step_pulse), .fetch_addr(fetch_addr), .fetch_word(fetch_word)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
        return (32'(i) * 32'h01F3_A5C7) ^ salt;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] s, input logic [7:0] d);
        reg_sel = s; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] s, output logic [7:0] d);
        reg_sel = s; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_addr(input int a);
        reg_wr(2'd2, 8'(a));
        reg_wr(2'd3, 8'(a >> 8));
    endtask

    task automatic write_word(input logic [31:0] w);
        for (int b = 0; b < 4; b++) reg_wr(2'd1, w[8*b +: 8]);
    endtask

    task automatic fetch_chk(input string req, input int a, input logic [31:0] exp);
        fetch_addr = 9'(a);
        #1 check(req, fetch_word, exp);
    endtask

    task automatic addr_chk(input string req, input int a);
        logic [7:0] v;
        reg_rd(2'd2, v); check(req, 32'(v), 32'(a & 255));
        reg_rd(2'd3, v); check(req, 32'(v), 32'((a >> 8) & 1));
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(2'd0, v); check("R1 ctrl", 32'(v), 32'h0);
        addr_chk("R1 addr", 0);
        check("R1 core_rst", 32'(core_rst), 32'h0);
        check("R1 step", 32'(step_pulse), 32'h0);

        // R2/R10 full sweep write, then fetch every word
        reg_wr(2'd0, 8'h01);
        set_addr(0);
        for (int w = 0; w < DEPTH; w++) begin
            model[w] = pat(w, 32'hC3A5_0F1E);
            write_word(model[w]);
        end
        addr_chk("R8 sweep wrap", 0);
        for (int w = 0; w < DEPTH; w++) fetch_chk("R2 R10 fetch", w, model[w]);

        // R7 window read sweep, byte order and advance
        set_addr(0);
        for (int w = 0; w < DEPTH; w++)
            for (int b = 0; b < 4; b++) begin
                reg_rd(2'd1, v);
                check("R7 read byte", 32'(v), 32'(model[w][8*b +: 8]));
            end
        addr_chk("R7 read wrap", 0);

        // R4 high register masking, R3/R11 partial word
        reg_wr(2'd2, 8'd44);
        reg_wr(2'd3, 8'hFF);
        reg_rd(2'd3, v); check("R4 hi readback", 32'(v), 32'h1);
        for (int b = 0; b < 3; b++) begin
            reg_wr(2'd1, 8'(8'h10 + b));
            addr_chk("R3 hold partial", 300);
            fetch_chk("R11 no partial commit", 300, model[300]);
        end
        reg_wr(2'd1, 8'h13);
        model[300] = 32'h1312_1110;
        fetch_chk("R2 commit on fourth", 300, model[300]);
        addr_chk("R3 advance", 301);

        // R5 lane clear on address write
        set_addr(10);
        reg_wr(2'd1, 8'hAA);
        reg_wr(2'd1, 8'hBB);
        reg_wr(2'd2, 8'd10);
        write_word(32'hDEAD_BEEF);
        model[10] = 32'hDEAD_BEEF;
        fetch_chk("R5 restart word", 10, model[10]);
        fetch_chk("R5 neighbour intact", 11, model[11]);
        addr_chk("R5 addr after", 11);
        set_addr(300);
        reg_rd(2'd1, v); reg_rd(2'd1, v);
        reg_wr(2'd3, 8'h01);
        reg_rd(2'd1, v); check("R5 read lane0", 32'(v), 32'(model[300][7:0]));

        // R8 explicit wrap from the top word
        set_addr(511);
        write_word(32'h0BAD_F00D);
        model[511] = 32'h0BAD_F00D;
        addr_chk("R8 wrap", 0);
        fetch_chk("R8 top word", 511, model[511]);

        // R6 disabled window
        reg_wr(2'd0, 8'h00);
        set_addr(5);
        write_word(32'h5555_AAAA);
        fetch_chk("R6 no write", 5, model[5]);
        addr_chk("R6 no advance wr", 5);
        for (int b = 0; b < 4; b++) reg_rd(2'd1, v);
        addr_chk("R6 no advance rd", 5);
        reg_wr(2'd0, 8'h01);
        reg_rd(2'd1, v); check("R6 lane still 0", 32'(v), 32'(model[5][7:0]));

        // R9 control bits
        reg_sel = 2'd0; wdata = 8'h07; wr_en = 1'b1;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
        check("R9 step high", 32'(step_pulse), 32'h1);
        check("R9 core_rst", 32'(core_rst), 32'h1);
        @(negedge clk);
        check("R9 step low", 32'(step_pulse), 32'h0);
        reg_rd(2'd0, v); check("R9 ctrl readback", 32'(v), 32'h3);
        reg_wr(2'd0, 8'h01);
        check("R9 core_rst clear", 32'(core_rst), 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule